// File: doc/BRIEF.md
# Two-Channel Byte-Loaded DAC Code Register

This block sits between an 8-bit processor bus and a two-channel 12-bit converter. Each channel keeps a staging register and an output register. The bus fills a staging register in two writes: a full low byte, and a high nibble that travels on the four lowest bus lines. The output codes change only when the output registers take a copy of the staging registers, and that copy is triggered by a separate active-low load pin.

A write happens in any clock cycle where chip select and the write strobe are both low. Two address lines choose the target. The more significant line selects the channel and the less significant line selects the half. The load pin is not tied to the bus clock domain, so it passes through a two-stage synchroniser first. For as long as the synchronised level stays low, both output registers copy their staging registers on every clock. The bus side is a plain strobed register port. It has no valid/ready handshake, because a write can never be held off.

Top module: `dac_byte_loader`

## Requirements
- R1: While reset is low, both staging registers and both output codes are held at zero.
- R2: A write to address 2'b00 puts data[7:0] into bits 7:0 of the channel A staging register. Bits 11:8 of that register and all of channel B are left unchanged.
- R3: A write to address 2'b01 puts data[3:0] into bits 11:8 of the channel A staging register. data[7:4] is ignored and bits 7:0 are unchanged.
- R4: Addresses 2'b10 and 2'b11 do the same as R2 and R3, but for channel B.
- R5: A cycle where cs_n or wr_n is high writes nothing.
- R6: A staging write alone never changes code_a or code_b.
- R7: ld_n is sampled low at a rising edge. The output codes take the staging values at the third rising edge counted from that edge, and not earlier.
- R8: While the synchronised load level stays low, each output code follows its staging register one clock behind.
- R9: A single load moves both channels at the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Active-low chip select |
| wr_n | input | 1 | Active-low write strobe |
| addr | input | 2 | Target: bit 1 selects the channel (0=A, 1=B), bit 0 selects the half (0=low byte, 1=high nibble) |
| data | input | 8 | Bus data |
| ld_n | input | 1 | Active-low load, asynchronous |
| code_a | output | 12 | Channel A output code |
| code_b | output | 12 | Channel B output code |

## Verification
A staging write is taken at the rising edge where cs_n and wr_n are both low. Its effect on the outputs is checked only after a load, and the output is sampled again straight after the write to confirm it has not moved. A load pulse reaches the outputs at the third rising edge. The bench samples one falling edge after the second edge and again after the third, which confirms both the no-earlier rule and the arrival. While ld_n is held low, the output is sampled on the falling edge one clock after the write edge. All sampling is done on falling edges.

// File: rtl/dac_byte_loader_pkg.sv
package dac_byte_loader_pkg;
  localparam int BUS_W  = 8;
  localparam int HI_W   = 4;
  localparam int CODE_W = BUS_W + HI_W;
  localparam int NCH    = 2;
  localparam int ADDR_W = $clog2(NCH) + 1;
  typedef logic [CODE_W-1:0] code_t;
endpackage

// File: rtl/dac_byte_loader_decode.sv
module dac_byte_loader_decode
  import dac_byte_loader_pkg::*;
(
  input  logic              cs_n,
  input  logic              wr_n,
  input  logic [ADDR_W-1:0] addr,
  output logic [NCH-1:0]    lo_we,
  output logic [NCH-1:0]    hi_we
);
  logic strobe;
  assign strobe = !cs_n && !wr_n;

  for (genvar ch = 0; ch < NCH; ch++) begin : g_dec
    logic hit;
    assign hit       = strobe && (addr[ADDR_W-1:1] == (ADDR_W-1)'(ch));
    assign lo_we[ch] = hit && !addr[0];
    assign hi_we[ch] = hit &&  addr[0];
  end
endmodule

// File: rtl/dac_byte_loader_sync.sv
module dac_byte_loader_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic sync_out
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (!rst_n) chain <= '1;
    else        chain <= {chain[STAGES-2:0], async_in};
  end

  assign sync_out = chain[STAGES-1];
endmodule

// File: rtl/dac_byte_loader_chan.sv
module dac_byte_loader_chan
  import dac_byte_loader_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lo_we,
  input  logic             hi_we,
  input  logic [BUS_W-1:0] data,
  input  logic             load,
  output code_t            stage_q,
  output code_t            out_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stage_q <= '0;
    end else begin
      if (lo_we) stage_q[BUS_W-1:0]      <= data;
      if (hi_we) stage_q[CODE_W-1:BUS_W] <= data[HI_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)    out_q <= '0;
    else if (load) out_q <= stage_q;
  end
endmodule

// File: rtl/dac_byte_loader.sv
module dac_byte_loader
  import dac_byte_loader_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              wr_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BUS_W-1:0]  data,
  input  logic              ld_n,
  output logic [CODE_W-1:0] code_a,
  output logic [CODE_W-1:0] code_b
);
  logic [NCH-1:0] lo_we;
  logic [NCH-1:0] hi_we;
  logic           ld_sync_n;
  code_t          stage_q [NCH];
  code_t          out_q   [NCH];

  dac_byte_loader_decode u_dec (
    .cs_n (cs_n),
    .wr_n (wr_n),
    .addr (addr),
    .lo_we(lo_we),
    .hi_we(hi_we)
  );

  dac_byte_loader_sync #(.STAGES(2)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_in(ld_n),
    .sync_out(ld_sync_n)
  );

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    dac_byte_loader_chan u_chan (
      .clk    (clk),
      .rst_n  (rst_n),
      .lo_we  (lo_we[ch]),
      .hi_we  (hi_we[ch]),
      .data   (data),
      .load   (!ld_sync_n),
      .stage_q(stage_q[ch]),
      .out_q  (out_q[ch])
    );
  end

  assign code_a = out_q[0];
  assign code_b = out_q[1];
endmodule

// File: rtl/dac_byte_loader_chk.sv
module dac_byte_loader_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cs_n,
  input logic        wr_n,
  input logic [1:0]  addr,
  input logic [7:0]  data,
  input logic        ld_n,
  input logic [11:0] code_a,
  input logic [11:0] code_b,
  input logic [11:0] stg_a,
  input logic [11:0] stg_b
);
  logic ld_m1, ld_m2;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ld_m1 <= 1'b1;
      ld_m2 <= 1'b1;
    end else begin
      ld_m1 <= ld_n;
      ld_m2 <= ld_m1;
    end
  end

  p_reset_clear_r1: assert property (@(posedge clk)
    !rst_n |=> (code_a == '0 && code_b == '0 && stg_a == '0 && stg_b == '0));

  p_low_byte_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && !wr_n && addr == 2'b00) |=>
      (stg_a[7:0] == $past(data) && $stable(stg_a[11:8]) && $stable(stg_b)));

  p_high_nibble_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && !wr_n && addr == 2'b01) |=>
      (stg_a[11:8] == $past(data[3:0]) && $stable(stg_a[7:0]) && $stable(stg_b)));

  p_chan_b_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && !wr_n && addr[1]) |=> $stable(stg_a));

  p_no_strobe_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n || wr_n) |=> ($stable(stg_a) && $stable(stg_b)));

  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ld_m2 |=> ($stable(code_a) && $stable(code_b)));

  p_track_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_m2 |=> (code_a == $past(stg_a) && code_b == $past(stg_b)));
endmodule

bind dac_byte_loader dac_byte_loader_chk u_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .cs_n  (cs_n),
  .wr_n  (wr_n),
  .addr  (addr),
  .data  (data),
  .ld_n  (ld_n),
  .code_a(code_a),
  .code_b(code_b),
  .stg_a (stage_q[0]),
  .stg_b (stage_q[1])
);

// File: tb/dac_byte_loader_bench.sv
module dac_byte_loader_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 8;
  // {addr, data, expected code_a, expected code_b} after write + load
  localparam logic [33:0] VEC [NVEC] = '{
    {2'b00, 8'hA5, 12'h0A5, 12'h000},
    {2'b01, 8'hF3, 12'h3A5, 12'h000},
    {2'b10, 8'h5C, 12'h3A5, 12'h05C},
    {2'b11, 8'h0E, 12'h3A5, 12'hE5C},
    {2'b00, 8'hFF, 12'h3FF, 12'hE5C},
    {2'b11, 8'h10, 12'h3FF, 12'h05C},
    {2'b01, 8'h0F, 12'hFFF, 12'h05C},
    {2'b10, 8'h00, 12'hFFF, 12'h000}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, wr_n = 1'b1, ld_n = 1'b1;
  logic [1:0] addr = '0;
  logic [7:0] data = '0;
  logic [11:0] code_a, code_b;
  int n_chk = 0, n_bad = 0;
  logic [11:0] pa, pb;

  always #(CLK_PERIOD/2) clk = ~clk;

  dac_byte_loader u_dac_byte_loader (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr_n(wr_n), .addr(addr),
    .data(data), .ld_n(ld_n), .code_a(code_a), .code_b(code_b)
  );

  task automatic check(input string req, input logic [11:0] ea, input logic [11:0] eb);
    n_chk++;
    if (code_a !== ea || code_b !== eb) begin
      n_bad++;
      $display("FAIL %s: code_a=%h code_b=%h expected %h %h", req, code_a, code_b, ea, eb);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [7:0] d,
                           input logic c = 1'b0, input logic w = 1'b0);
    @(negedge clk); cs_n = c; wr_n = w; addr = a; data = d;
    @(negedge clk); cs_n = 1'b1; wr_n = 1'b1;
  endtask

  task automatic load_pulse();
    @(negedge clk); ld_n = 1'b0;
    @(negedge clk); ld_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset", 12'h000, 12'h000);
    rst_n = 1'b1;
    pa = '0; pb = '0;

    for (int i = 0; i < NVEC; i++) begin
      bus_write(VEC[i][33:32], VEC[i][31:24]);
      check("R6 write alone", pa, pb);
      load_pulse();
      check("R2 R3 R4 R9 load", VEC[i][23:12], VEC[i][11:0]);
      pa = VEC[i][23:12]; pb = VEC[i][11:0];
    end

    // R5: chip select high, then strobe high
    bus_write(2'b00, 8'h77, 1'b1, 1'b0);
    bus_write(2'b10, 8'h77, 1'b0, 1'b1);
    load_pulse();
    check("R5 ignored", pa, pb);

    // R7 latency
    bus_write(2'b00, 8'h3C);
    @(negedge clk); ld_n = 1'b0;
    @(negedge clk); ld_n = 1'b1;
    @(negedge clk);
    check("R7 not early", pa, pb);
    @(negedge clk);
    check("R7 arrival", 12'hF3C, pb);
    pa = 12'hF3C;

    // R8 tracking while held low
    @(negedge clk); ld_n = 1'b0;
    repeat (3) @(negedge clk);
    cs_n = 1'b0; wr_n = 1'b0; addr = 2'b11; data = 8'h09;
    @(negedge clk); cs_n = 1'b1; wr_n = 1'b1;
    check("R8 not yet", pa, pb);
    @(negedge clk);
    check("R8 track", pa, 12'h900);
    ld_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 mid-run reset clears staging too
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 mid reset", 12'h000, 12'h000);
    rst_n = 1'b1;
    load_pulse();
    check("R1 staging clear", 12'h000, 12'h000);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 5000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule